// File: doc/BRIEF.md
# Bus-Master Channel Register Window

This block is the register front end of a two-channel bus-master storage controller. It sits behind a 16-byte I/O window. Each channel owns an 8-byte slice: the lower four bytes are byte-wide control registers, and the upper four bytes hold the 32-bit base address of that channel's descriptor table. The block decodes each access from its address and size, applies the write behaviour of the addressed register, and returns read data one cycle after a read request.

The mode byte is not stored here. It belongs to the interrupt logic and is shared by both channels. The window reads the whole byte from the `mode_in` input. A write through the window changes only the two interrupt block bits. It is passed out as a one-cycle `mode_wr` strobe carrying the merged value, and the interrupt logic uses that strobe to update its mirrors and its shared interrupt line. A write to a command byte is stored for read-back and also forwarded to the transfer engine as a one-cycle strobe. The engine in turn sets the active, error and interrupt flags of a channel's status byte through set pulses.

Top module: `bmwin_top`

## Requirements
- R1: Address bit 3 selects the channel (0 or 1). Address bits 2:0 select the byte within that channel's slice: offset 0 is command, 1 is the shared mode byte, 2 is status, 3 is timing, and offsets 4 to 7 are the descriptor address register.
- R2: A read request puts `rsp_valid` high with its data on `rsp_rdata` exactly one cycle later, with the unused upper bits zero. A write request produces no `rsp_valid`.
- R3: `req_size` encodes 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = reserved. Offsets 0 to 3 accept only byte accesses. The address register accepts a byte at any offset, a 16-bit access at an even offset and a 32-bit access at offset 4. Any other access reads as all ones over its width (0x0000FFFF for size 1, 0xFFFFFFFF for sizes 2 and 3) and has no effect when written.
- R4: A byte write to offset 1 of either channel pulses `mode_wr` for one cycle, one cycle after the request. `mode_wdata` then equals the `mode_in` value of the request cycle with bits 4 and 5 replaced by bits 4 and 5 of the written byte. A byte read at offset 1 returns `mode_in`.
- R5: A status write copies written bits 5 and 6 into the status byte, leaves bit 0 unchanged, and clears bit 1 and bit 2 only where the written bit is one. Status bits 3, 4 and 7 always read as zero.
- R6: The engine pulses `act_set`, `err_set` and `irq_set` set status bits 0, 1 and 2, and `act_clr` clears bit 0. A set pulse wins over a clear in the same cycle, whether that clear comes from `act_clr` or from a write-one-to-clear.
- R7: Each channel has its own fully read/write timing byte at offset 3.
- R8: The command byte reads back its last written value. A write to it raises the channel's bit of `cmd_stb` for exactly one cycle, one cycle after the request, with the value on `cmd_data`. At most one strobe bit is high at a time.
- R9: The descriptor address register takes writes on the byte lanes the access covers. Its bits 1:0 always read as zero. Its value appears on that channel's 32-bit slice of `prd_addr`, with channel 0 in bits 31:0.
- R10: After reset all registers read as zero and no strobe or response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Window byte address |
| req_size | input | 2 | Access size code (0 byte, 1 16-bit, 2 32-bit, 3 reserved) |
| req_wdata | input | 32 | Write data, aligned to bit 0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, aligned to bit 0 |
| mode_in | input | 8 | Current shared mode byte from the interrupt logic |
| mode_wr | output | 1 | Mode byte update strobe |
| mode_wdata | output | 8 | Merged mode byte to store |
| cmd_stb | output | 2 | Per-channel command write strobe |
| cmd_data | output | 8 | Command value written |
| act_set | input | 2 | Per-channel set of status active bit |
| act_clr | input | 2 | Per-channel clear of status active bit |
| err_set | input | 2 | Per-channel set of status error bit |
| irq_set | input | 2 | Per-channel set of status interrupt bit |
| prd_addr | output | 64 | Descriptor table base address per channel |

## Verification
The bench goes after the status merge. It writes all ones, then zero, then a clear that lands in the same cycle as a set pulse. A design that clears the active bit on write, keeps the read/write bits sticky, or lets the clear beat the set reads back a wrong status byte. The mode write is checked with a `mode_in` value whose other bits are non-zero, so a design that stores the whole written byte, or drops the bits it does not own, shows a wrong `mode_wdata`. Non-byte accesses to the control bytes, unaligned and reserved-size accesses to the address register, and byte writes to its lowest lane are each followed by a read-back. A design that half-accepts such an access, or stores address bits 1:0, shows a changed register or data that is not all ones.

// File: rtl/bmwin_pkg.sv
package bmwin_pkg;

   // bytes owned by one channel inside the window
   localparam int CH_SPAN = 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   // control byte offsets inside a channel slice
   localparam logic [1:0] OFF_CMD  = 2'd0;
   localparam logic [1:0] OFF_MODE = 2'd1;
   localparam logic [1:0] OFF_STAT = 2'd2;
   localparam logic [1:0] OFF_TIM  = 2'd3;

   // status byte fields
   localparam int         ST_ACT     = 0;
   localparam int         ST_ERR     = 1;
   localparam int         ST_IRQ     = 2;
   localparam logic [7:0] ST_RW_MASK  = 8'h60;
   localparam logic [7:0] ST_W1C_MASK = 8'h06;

   // bits of the shared mode byte owned by this window
   localparam logic [7:0] MODE_BLK_MASK = 8'h30;

   function automatic logic [31:0] fill_ones(acc_size_e s);
      case (s)
         SZ_BYTE: return 32'h0000_00FF;
         SZ_HALF: return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/bmwin_decode.sv
module bmwin_decode
   import bmwin_pkg::*;
#(
   parameter int NUM_CH = 2,
   localparam int AW  = $clog2(NUM_CH * CH_SPAN),
   localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [AW-1:0]  req_addr,
   input  acc_size_e      req_size,
   input  logic [31:0]    req_wdata,
   output logic           legal,
   output logic           is_ctrl,
   output logic [1:0]     off,
   output logic [CHW-1:0] ch_idx,
   output logic [3:0]     lane_mask,
   output logic [31:0]    wlane
);

   assign is_ctrl = ~req_addr[2];
   assign off     = req_addr[1:0];
   assign wlane   = req_wdata << {req_addr[1:0], 3'b000};

   generate
      if (NUM_CH > 1) begin : g_multi
         assign ch_idx = req_addr[AW-1:3];
      end else begin : g_single
         assign ch_idx = '0;
      end
   endgenerate

   always_comb begin
      legal     = 1'b0;
      lane_mask = 4'b0000;
      case (req_size)
         SZ_BYTE: begin
            legal     = 1'b1;
            lane_mask = 4'b0001 << req_addr[1:0];
         end
         SZ_HALF: begin
            legal     = ~is_ctrl & ~req_addr[0];
            lane_mask = 4'b0011 << req_addr[1:0];
         end
         SZ_WORD: begin
            legal     = ~is_ctrl & (req_addr[1:0] == 2'b00);
            lane_mask = 4'b1111;
         end
         default: begin
            legal     = 1'b0;
            lane_mask = 4'b0000;
         end
      endcase
   end

endmodule

// File: rtl/bmwin_chan.sv
module bmwin_chan
   import bmwin_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        is_ctrl,
   input  logic [1:0]  off,
   input  logic [3:0]  lane_mask,
   input  logic [31:0] wlane,
   input  logic        act_set,
   input  logic        act_clr,
   input  logic        err_set,
   input  logic        irq_set,
   output logic [7:0]  cmd_q,
   output logic [7:0]  stat_q,
   output logic [7:0]  tim_q,
   output logic [31:0] addr_q,
   output logic        cmd_stb
);

   logic       wr_cmd, wr_stat, wr_tim, wr_addr;
   logic [7:0] wbyte;
   logic [7:0] stat_d;
   logic [31:0] addr_d;

   assign wbyte   = wlane[{off, 3'b000} +: 8];
   assign wr_cmd  = wr_en & is_ctrl & (off == OFF_CMD);
   assign wr_stat = wr_en & is_ctrl & (off == OFF_STAT);
   assign wr_tim  = wr_en & is_ctrl & (off == OFF_TIM);
   assign wr_addr = wr_en & ~is_ctrl;

   always_comb begin
      stat_d = stat_q;
      if (wr_stat) begin
         stat_d = (wbyte & ST_RW_MASK)
                | (stat_q & 8'h01)
                | (stat_q & ~wbyte & ST_W1C_MASK);
      end
      if (act_set)      stat_d[ST_ACT] = 1'b1;
      else if (act_clr) stat_d[ST_ACT] = 1'b0;
      if (err_set)      stat_d[ST_ERR] = 1'b1;
      if (irq_set)      stat_d[ST_IRQ] = 1'b1;
   end

   always_comb begin
      addr_d = addr_q;
      for (int b = 0; b < 4; b++) begin
         if (wr_addr && lane_mask[b]) addr_d[b*8 +: 8] = wlane[b*8 +: 8];
      end
      addr_d[1:0] = 2'b00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         stat_q  <= '0;
         tim_q   <= '0;
         addr_q  <= '0;
         cmd_stb <= 1'b0;
      end else begin
         cmd_stb <= wr_cmd;
         stat_q  <= stat_d;
         addr_q  <= addr_d;
         if (wr_cmd) cmd_q <= wbyte;
         if (wr_tim) tim_q <= wbyte;
      end
   end

   // R5: bits 3, 4 and 7 of the status byte never become one
   p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[3] == 1'b0) && (stat_q[4] == 1'b0) && (stat_q[7] == 1'b0));

   // R5: the status byte holds when nothing touches it
   p_stat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stat && !act_set && !act_clr && !err_set && !irq_set) |=> $stable(stat_q));

   // R6: a set pulse always lands, even against a same-cycle clear
   p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> stat_q[ST_ERR]);
   p_act_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act_set |=> stat_q[ST_ACT]);

   // R9: the two low address bits never hold a one
   p_addr_lsb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      addr_q[1:0] == 2'b00);

   // R8: the command strobe lasts one cycle per write
   p_cmd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && !wr_cmd) |=> !cmd_stb);

endmodule

// File: rtl/bmwin_rdmux.sv
module bmwin_rdmux
   import bmwin_pkg::*;
(
   input  logic        legal,
   input  logic        is_ctrl,
   input  logic [1:0]  off,
   input  acc_size_e   size,
   input  logic [7:0]  cmd_b,
   input  logic [7:0]  mode_b,
   input  logic [7:0]  stat_b,
   input  logic [7:0]  tim_b,
   input  logic [31:0] addr_w,
   output logic [31:0] rdata
);

   logic [31:0] shifted;

   assign shifted = addr_w >> {off, 3'b000};

   always_comb begin
      if (!legal) begin
         rdata = fill_ones(size);
      end else if (is_ctrl) begin
         case (off)
            OFF_CMD:  rdata = {24'h0, cmd_b};
            OFF_MODE: rdata = {24'h0, mode_b};
            OFF_STAT: rdata = {24'h0, stat_b};
            default:  rdata = {24'h0, tim_b};
         endcase
      end else begin
         rdata = shifted & fill_ones(size);
      end
   end

endmodule

// File: rtl/bmwin_top.sv
module bmwin_top
   import bmwin_pkg::*;
#(
   parameter int NUM_CH = 2,
   localparam int AW  = $clog2(NUM_CH * CH_SPAN),
   localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [AW-1:0]        req_addr,
   input  logic [1:0]           req_size,
   input  logic [31:0]          req_wdata,
   output logic                 rsp_valid,
   output logic [31:0]          rsp_rdata,
   input  logic [7:0]           mode_in,
   output logic                 mode_wr,
   output logic [7:0]           mode_wdata,
   output logic [NUM_CH-1:0]    cmd_stb,
   output logic [7:0]           cmd_data,
   input  logic [NUM_CH-1:0]    act_set,
   input  logic [NUM_CH-1:0]    act_clr,
   input  logic [NUM_CH-1:0]    err_set,
   input  logic [NUM_CH-1:0]    irq_set,
   output logic [NUM_CH*32-1:0] prd_addr
);

   // the shared mode byte carries one block bit per channel, so two at most
   generate
      if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
         $error("bmwin_top: NUM_CH must be 1 or 2");
      end
   endgenerate

   acc_size_e      size_e;
   logic           legal, is_ctrl;
   logic [1:0]     off;
   logic [CHW-1:0] ch_idx;
   logic [3:0]     lane_mask;
   logic [31:0]    wlane;
   logic           wr_ok, rd_req, mode_hit;
   logic [31:0]    rdata_c;

   logic [7:0]  cmd_arr  [NUM_CH];
   logic [7:0]  stat_arr [NUM_CH];
   logic [7:0]  tim_arr  [NUM_CH];
   logic [31:0] addr_arr [NUM_CH];

   assign size_e   = acc_size_e'(req_size);
   assign wr_ok    = req_valid & req_write & legal;
   assign rd_req   = req_valid & ~req_write;
   assign mode_hit = wr_ok & is_ctrl & (off == OFF_MODE);

   bmwin_decode #(.NUM_CH(NUM_CH)) u_decode (
      .req_addr  (req_addr),
      .req_size  (size_e),
      .req_wdata (req_wdata),
      .legal     (legal),
      .is_ctrl   (is_ctrl),
      .off       (off),
      .ch_idx    (ch_idx),
      .lane_mask (lane_mask),
      .wlane     (wlane)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         bmwin_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_ok && (ch_idx == CHW'(c))),
            .is_ctrl   (is_ctrl),
            .off       (off),
            .lane_mask (lane_mask),
            .wlane     (wlane),
            .act_set   (act_set[c]),
            .act_clr   (act_clr[c]),
            .err_set   (err_set[c]),
            .irq_set   (irq_set[c]),
            .cmd_q     (cmd_arr[c]),
            .stat_q    (stat_arr[c]),
            .tim_q     (tim_arr[c]),
            .addr_q    (addr_arr[c]),
            .cmd_stb   (cmd_stb[c])
         );
         assign prd_addr[c*32 +: 32] = addr_arr[c];
      end
   endgenerate

   bmwin_rdmux u_rdmux (
      .legal   (legal),
      .is_ctrl (is_ctrl),
      .off     (off),
      .size    (size_e),
      .cmd_b   (cmd_arr[ch_idx]),
      .mode_b  (mode_in),
      .stat_b  (stat_arr[ch_idx]),
      .tim_b   (tim_arr[ch_idx]),
      .addr_w  (addr_arr[ch_idx]),
      .rdata   (rdata_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         mode_wr    <= 1'b0;
         mode_wdata <= '0;
         cmd_data   <= '0;
      end else begin
         rsp_valid <= rd_req;
         mode_wr   <= mode_hit;
         if (rd_req) rsp_rdata <= rdata_c;
         if (mode_hit) begin
            mode_wdata <= (mode_in & ~MODE_BLK_MASK) | (wlane[15:8] & MODE_BLK_MASK);
         end
         if (wr_ok && is_ctrl && off == OFF_CMD) cmd_data <= wlane[7:0];
      end
   end

   // R2: every read is answered on the next cycle, writes never are
   p_rsp_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid);
   p_rsp_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rsp_valid);

   // R4: mode update keeps every bit the window does not own
   p_mode_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 2'd0 && req_addr[2:0] == 3'd1)
      |=> (mode_wr && ((mode_wdata & ~MODE_BLK_MASK) == ($past(mode_in) & ~MODE_BLK_MASK))));

   // R3: a non-byte write at a control offset never reaches the mode byte
   p_mode_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size != 2'd0 && !req_addr[2]) |=> !mode_wr);

   // R8: only one channel strobes a command at a time
   p_cmd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_stb));

endmodule

// File: tb/bmwin_top_tb.sv
module bmwin_top_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [7:0]  mode_in = 8'h00;
   logic        mode_wr;
   logic [7:0]  mode_wdata;
   logic [1:0]  cmd_stb;
   logic [7:0]  cmd_data;
   logic [1:0]  act_set = '0, act_clr = '0, err_set = '0, irq_set = '0;
   logic [63:0] prd_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bmwin_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mode_in(mode_in), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .cmd_stb(cmd_stb), .cmd_data(cmd_data),
      .act_set(act_set), .act_clr(act_clr), .err_set(err_set), .irq_set(irq_set),
      .prd_addr(prd_addr)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // one access; returns at the negedge after the request edge, with outputs settled
   task automatic access(input bit wr, input logic [3:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd, output logic rv);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      rd = rsp_rdata; rv = rsp_valid;
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] wd);
      logic [31:0] rd; logic rv;
      access(1'b1, a, sz, wd, rd, rv);
   endtask

   task automatic rd_check(input string tag, input logic [3:0] a, input logic [1:0] sz,
                           input logic [31:0] exp);
      logic [31:0] rd; logic rv;
      access(1'b0, a, sz, 32'h0, rd, rv);
      check({tag, " rsp_valid"}, 64'(rv), 64'd1);
      check(tag, 64'(rd), 64'(exp));
   endtask

   task automatic pulses(input logic [1:0] as, input logic [1:0] ac,
                         input logic [1:0] es, input logic [1:0] is);
      @(negedge clk);
      act_set = as; act_clr = ac; err_set = es; irq_set = is;
      @(negedge clk);
      act_set = '0; act_clr = '0; err_set = '0; irq_set = '0;
   endtask

   task automatic t_reset;
      check("R10 rsp_valid", 64'(rsp_valid), 64'd0);
      check("R10 cmd_stb", 64'(cmd_stb), 64'd0);
      check("R10 mode_wr", 64'(mode_wr), 64'd0);
      check("R10 prd_addr", prd_addr, 64'd0);
      rd_check("R10 status ch0", 4'd2, 2'd0, 32'h0);
      rd_check("R10 cmd ch1", 4'd8, 2'd0, 32'h0);
   endtask

   task automatic t_command;
      logic [31:0] rd; logic rv;
      access(1'b1, 4'd8, 2'd0, 32'h09, rd, rv);
      check("R2 no rsp on write", 64'(rv), 64'd0);
      check("R8 cmd_stb ch1", 64'(cmd_stb), 64'b10);
      check("R8 cmd_data", 64'(cmd_data), 64'h09);
      @(negedge clk);
      check("R8 strobe one cycle", 64'(cmd_stb), 64'd0);
      rd_check("R8 cmd ch1 readback", 4'd8, 2'd0, 32'h09);
      rd_check("R1 cmd ch0 untouched", 4'd0, 2'd0, 32'h0);
   endtask

   task automatic t_mode;
      mode_in = 8'h3C;
      wr(4'd1, 2'd0, 32'h0000_00D0);
      check("R4 mode_wr", 64'(mode_wr), 64'd1);
      check("R4 mode_wdata", 64'(mode_wdata), 64'h1C);
      wr(4'd9, 2'd0, 32'h0000_0020);
      check("R4 mode_wdata ch1", 64'(mode_wdata), 64'h2C);
      rd_check("R4 mode read ch1", 4'd9, 2'd0, 32'h3C);
      wr(4'd1, 2'd1, 32'h0000_3030);
      check("R3 no mode_wr on 16-bit write", 64'(mode_wr), 64'd0);
   endtask

   task automatic t_status;
      pulses(2'b01, 2'b00, 2'b01, 2'b01);
      rd_check("R6 set pulses", 4'd2, 2'd0, 32'h07);
      wr(4'd2, 2'd0, 32'hFF);
      rd_check("R5 write ones", 4'd2, 2'd0, 32'h61);
      wr(4'd2, 2'd0, 32'h00);
      rd_check("R5 write zero keeps active", 4'd2, 2'd0, 32'h01);
      pulses(2'b00, 2'b01, 2'b00, 2'b00);
      rd_check("R6 active clear", 4'd2, 2'd0, 32'h00);
      rd_check("R1 status ch1 untouched", 4'd10, 2'd0, 32'h00);
   endtask

   task automatic t_priority;
      pulses(2'b00, 2'b00, 2'b01, 2'b00);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd2; req_size = 2'd0;
      req_wdata = 32'h02; err_set = 2'b01; act_set = 2'b01; act_clr = 2'b01;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      err_set = '0; act_set = '0; act_clr = '0;
      rd_check("R6 set beats clear", 4'd2, 2'd0, 32'h03);
      wr(4'd2, 2'd0, 32'h06);
      rd_check("R5 w1c error", 4'd2, 2'd0, 32'h01);
   endtask

   task automatic t_timing;
      wr(4'd3, 2'd0, 32'hA5);
      wr(4'd11, 2'd0, 32'h5A);
      rd_check("R7 timing ch0", 4'd3, 2'd0, 32'hA5);
      rd_check("R7 timing ch1", 4'd11, 2'd0, 32'h5A);
   endtask

   task automatic t_address;
      wr(4'd4, 2'd2, 32'h1234_5677);
      rd_check("R9 word write", 4'd4, 2'd2, 32'h1234_5674);
      wr(4'd6, 2'd0, 32'hAB);
      rd_check("R9 byte lane", 4'd5, 2'd0, 32'h56);
      check("R9 prd_addr ch0", 64'(prd_addr[31:0]), 64'h12AB_5674);
      wr(4'd4, 2'd0, 32'hFF);
      rd_check("R9 low bits zero", 4'd4, 2'd0, 32'hFC);
      wr(4'd12, 2'd1, 32'hBEEF);
      wr(4'd14, 2'd1, 32'h1234);
      rd_check("R9 half lanes ch1", 4'd12, 2'd2, 32'h1234_BEEC);
      rd_check("R9 half read", 4'd14, 2'd1, 32'h1234);
      check("R9 prd_addr ch1", 64'(prd_addr[63:32]), 64'h1234_BEEC);
   endtask

   task automatic t_size;
      wr(4'd13, 2'd2, 32'hFFFF_FFFF);
      check("R3 unaligned write ignored", 64'(prd_addr[63:32]), 64'h1234_BEEC);
      rd_check("R3 unaligned word read", 4'd13, 2'd2, 32'hFFFF_FFFF);
      rd_check("R3 16-bit control read", 4'd2, 2'd1, 32'h0000_FFFF);
      rd_check("R3 32-bit control read", 4'd0, 2'd2, 32'hFFFF_FFFF);
      wr(4'd3, 2'd1, 32'h7777);
      rd_check("R3 16-bit timing write ignored", 4'd3, 2'd0, 32'hA5);
      rd_check("R3 reserved size read", 4'd4, 2'd3, 32'hFFFF_FFFF);
      wr(4'd4, 2'd3, 32'h0);
      check("R3 reserved size write ignored", 64'(prd_addr[31:0]), 64'h12AB_56FC);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_command();
      t_mode();
      t_status();
      t_priority();
      t_timing();
      t_address();
      t_size();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule